// File: doc/BRIEF.md
# Bus-Master DMA Control Register Set

This block holds the software-visible control registers that steer a bus-master DMA engine on a disk interface with several channels, two by default. Each channel has three registers: a command byte that starts and stops transfers and sets their direction, a status byte that reports activity, interrupt and error, and a 32-bit pointer to the descriptor table in memory. Writes go through one write port that carries an offset and an access size. Each register applies its own write rule: a direction bit that is frozen while a transfer runs, write-one-to-clear status flags, an activity flag that only the start/stop edges can move, and a pointer that is always kept dword aligned.

When the start bit goes from 0 to 1, or from 1 to 0, the block sends a one-cycle start or stop pulse to that channel's DMA engine. The pulse is tagged with the drive that the channel's drive-select input names. The engine reports completion interrupts and transfer errors back through per-channel set inputs. Descriptor fetch, data movement and PCI address decode are handled outside this block. The bus-master enable input gates every write.

Top module: `busmaster_regs`

## Requirements
- R1: After reset every command register reads 0x00, every status register reads 0x60, every pointer reads 0, and no start or stop pulse is driven.
- R2: Channel c's registers sit at offset 8*c: command at +0, status at +2, pointer at +4. Reads of any other offset return 0. In the command byte, bit 0 is start and bit 3 is direction, and every other bit reads 0.
- R3: While the start bit is 1, a command write leaves the direction bit unchanged. This includes the write that clears start.
- R4: A command write that moves start from 0 to 1, with the selected drive present, sets status bit 0 (active). One cycle after that write edge it raises `dma_start[c]` for exactly one cycle, with `dma_drive[c]` equal to `drive_sel[c]`.
- R5: A command write that moves start from 1 to 0 clears the active bit and raises `dma_stop[c]` for exactly one cycle, tagged with the drive.
- R6: Status bit 2 (interrupt) and status bit 1 (error) are cleared by writing 1 to them. Writing 0 leaves them unchanged, and a software write never sets them. `irq_set[c]` and `err_set[c]` set them.
- R7: Software writes to status bit 0 (active) are ignored. Status bits 6 and 5 (drive 1 and drive 0 DMA capable) are read/write, and the other status bits read 0.
- R8: A dword write to the pointer stores the data with its two low bits forced to 0.
- R9: A write is taken only with the right size (`wr_size` 0 = byte, 1 = halfword, 2 = dword): a byte write for the command and status registers, a dword write for the pointer. Any other size leaves the register unchanged and sends no pulse.
- R10: While `bm_en` is 0, every write is ignored.
- R11: If the engine sets the interrupt or error flag in the same cycle that software clears it, the flag ends up set.
- R12: A 0-to-1 start write on a channel whose selected drive is absent (`drive_present[2*c + drive_sel[c]]` = 0) leaves start at 0 and the active bit at 0, sends no start pulse, and sets the error flag.
- R13: The channels are independent. A write or engine input on one channel changes nothing on another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bm_en | input | 1 | Bus-master enable; writes are ignored while low |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | CH_W+3 (4) | Write offset within the bus-master block |
| wr_size | input | 2 | Access size: 0 byte, 1 halfword, 2 dword |
| wr_data | input | 32 | Write data, low-aligned |
| rd_addr | input | CH_W+3 (4) | Read offset |
| rd_data | output | 32 | Combinational read data for rd_addr |
| drive_sel | input | NCH | Per channel: selected drive (0 or 1) |
| drive_present | input | 2*NCH | Drive presence, bit 2*c+d for drive d of channel c |
| irq_set | input | NCH | Engine sets the channel's interrupt flag |
| err_set | input | NCH | Engine sets the channel's error flag |
| dma_start | output | NCH | One-cycle start pulse per channel |
| dma_stop | output | NCH | One-cycle stop/abort pulse per channel |
| dma_drive | output | NCH | Drive tag that goes with the last start or stop pulse |

## Verification
A start bit that is out of step with the active flag shows on the first read of the status byte after the command write, and on the missing or extra pulse one cycle after that write edge. A lost direction lock or a wrong write-one-to-clear mask shows in the very next read of the command or status byte, so every scenario reads back right after the write. Stray writes to a neighbouring channel and the priority of hardware sets over clears only show when both channels are read back after one of them is disturbed, so the bench does exactly that.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
   // sub-offsets inside one channel window
   localparam logic [2:0] SUB_CMD = 3'd0;
   localparam logic [2:0] SUB_STS = 3'd2;
   localparam logic [2:0] SUB_PTR = 3'd4;

   // command bits
   localparam int CMD_GO  = 0;
   localparam int CMD_DIR = 3;

   // status bits
   localparam int STS_ACT  = 0;
   localparam int STS_ERR  = 1;
   localparam int STS_IRQ  = 2;
   localparam int STS_CAP0 = 5;
   localparam int STS_CAP1 = 6;

   localparam logic [7:0] STS_RESET = 8'h60;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } wsize_e;
endpackage

// File: rtl/bmr_decode.sv
module bmr_decode
   import bmr_pkg::*;
#(
   parameter int NCH  = 2,
   parameter int CH_W = $clog2(NCH),
   parameter int AW   = CH_W + 3
) (
   input  logic            bm_en,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [1:0]      wr_size,
   output logic [NCH-1:0]  cmd_we,
   output logic [NCH-1:0]  sts_we,
   output logic [NCH-1:0]  ptr_we
);
   logic            hit;
   logic [2:0]      sub;
   logic [CH_W-1:0] ch;
   logic            is_byte, is_word;

   assign hit     = bm_en & wr_en;
   assign sub     = wr_addr[2:0];
   assign ch      = wr_addr[AW-1:3];
   assign is_byte = (wr_size == SZ_BYTE);
   assign is_word = (wr_size == SZ_WORD);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic sel;
      assign sel       = hit && (ch == CH_W'(c));
      assign cmd_we[c] = sel && (sub == SUB_CMD) && is_byte;
      assign sts_we[c] = sel && (sub == SUB_STS) && is_byte;
      assign ptr_we[c] = sel && (sub == SUB_PTR) && is_word;
   end

   // at most one register is written per access
   always_comb begin
      assert_one_target_R9: assert ($onehot0({cmd_we, sts_we, ptr_we}))
         else $error("more than one register strobed");
      assert_gate_R10: assert (bm_en || ($countones({cmd_we, sts_we, ptr_we}) == 0))
         else $error("write strobe while bus master disabled");
   end
endmodule

// File: rtl/bmr_channel.sv
module bmr_channel
   import bmr_pkg::*;
#(
   parameter int PTR_W  = 32,
   parameter bit CAP_RW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic             sts_we,
   input  logic             ptr_we,
   input  logic [31:0]      wdata,
   input  logic             drv_sel,
   input  logic [1:0]       drv_present,
   input  logic             irq_set,
   input  logic             err_set,
   output logic [7:0]       cmd_rd,
   output logic [7:0]       sts_rd,
   output logic [PTR_W-1:0] ptr_rd,
   output logic             start_p,
   output logic             stop_p,
   output logic             drive_tag
);
   logic             go_q, dir_q, act_q, irq_q, err_q;
   logic [1:0]       cap_q;
   logic [PTR_W-1:0] ptr_q;

   logic present, go_rise, go_fall, start_ok, start_bad;
   logic irq_clr, err_clr;

   assign present   = drv_present[drv_sel];
   assign go_rise   = cmd_we && !go_q && wdata[CMD_GO];
   assign go_fall   = cmd_we &&  go_q && !wdata[CMD_GO];
   assign start_ok  = go_rise &&  present;
   assign start_bad = go_rise && !present;
   assign irq_clr   = sts_we && wdata[STS_IRQ];
   assign err_clr   = sts_we && wdata[STS_ERR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_q      <= 1'b0;
         dir_q     <= 1'b0;
         act_q     <= 1'b0;
         irq_q     <= 1'b0;
         err_q     <= 1'b0;
         ptr_q     <= '0;
         start_p   <= 1'b0;
         stop_p    <= 1'b0;
         drive_tag <= 1'b0;
      end else begin
         if (cmd_we) begin
            go_q <= wdata[CMD_GO] && (go_q || present);
            if (!go_q) dir_q <= wdata[CMD_DIR];
         end
         if (start_ok)     act_q <= 1'b1;
         else if (go_fall) act_q <= 1'b0;
         irq_q <= irq_set | (irq_q & ~irq_clr);
         err_q <= err_set | start_bad | (err_q & ~err_clr);
         if (ptr_we) ptr_q <= {wdata[PTR_W-1:2], 2'b00};
         start_p <= start_ok;
         stop_p  <= go_fall;
         if (start_ok || go_fall) drive_tag <= drv_sel;
      end
   end

   if (CAP_RW) begin : g_cap_rw
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cap_q <= STS_RESET[STS_CAP1:STS_CAP0];
         else if (sts_we) cap_q <= wdata[STS_CAP1:STS_CAP0];
      end
   end else begin : g_cap_fixed
      assign cap_q = STS_RESET[STS_CAP1:STS_CAP0];
   end

   assign cmd_rd = {4'b0000, dir_q, 2'b00, go_q};
   assign sts_rd = {1'b0, cap_q, 2'b00, irq_q, err_q, act_q};
   assign ptr_rd = ptr_q;

   assert_dir_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      go_q |=> (dir_q == $past(dir_q)))
      else $error("direction changed while running");

   assert_start_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |-> (act_q && go_q && !stop_p))
      else $error("start pulse without active state");

   assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_p |=> !start_p)
      else $error("start pulse longer than one cycle");

   assert_stop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stop_p |-> (!act_q && !go_q))
      else $error("stop pulse while still active");

   assert_irq_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set |=> irq_q)
      else $error("engine interrupt set lost");

   assert_err_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> err_q)
      else $error("engine error set lost");

   assert_no_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !go_q && wdata[CMD_GO] && !drv_present[drv_sel]) |=> (!start_p && !go_q && err_q))
      else $error("start issued to absent drive");
endmodule

// File: rtl/busmaster_regs.sv
module busmaster_regs
   import bmr_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int PTR_W  = 32,
   parameter bit CAP_RW = 1'b1,
   parameter int CH_W   = $clog2(NCH),
   parameter int AW     = CH_W + 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bm_en,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [1:0]       wr_size,
   input  logic [31:0]      wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [31:0]      rd_data,
   input  logic [NCH-1:0]   drive_sel,
   input  logic [2*NCH-1:0] drive_present,
   input  logic [NCH-1:0]   irq_set,
   input  logic [NCH-1:0]   err_set,
   output logic [NCH-1:0]   dma_start,
   output logic [NCH-1:0]   dma_stop,
   output logic [NCH-1:0]   dma_drive
);
   if (NCH < 2 || NCH > 8) begin : g_bad_nch
      $error("NCH must lie in 2..8");
   end
   if (PTR_W < 3 || PTR_W > 32) begin : g_bad_ptr
      $error("PTR_W must lie in 3..32");
   end

   logic [NCH-1:0] cmd_we, sts_we, ptr_we;
   logic [7:0]       cmd_v [NCH];
   logic [7:0]       sts_v [NCH];
   logic [PTR_W-1:0] ptr_v [NCH];

   bmr_decode #(.NCH(NCH), .CH_W(CH_W), .AW(AW)) i_decode (
      .bm_en   (bm_en),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_size (wr_size),
      .cmd_we  (cmd_we),
      .sts_we  (sts_we),
      .ptr_we  (ptr_we)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      bmr_channel #(.PTR_W(PTR_W), .CAP_RW(CAP_RW)) i_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .cmd_we      (cmd_we[c]),
         .sts_we      (sts_we[c]),
         .ptr_we      (ptr_we[c]),
         .wdata       (wr_data),
         .drv_sel     (drive_sel[c]),
         .drv_present (drive_present[2*c+1 : 2*c]),
         .irq_set     (irq_set[c]),
         .err_set     (err_set[c]),
         .cmd_rd      (cmd_v[c]),
         .sts_rd      (sts_v[c]),
         .ptr_rd      (ptr_v[c]),
         .start_p     (dma_start[c]),
         .stop_p      (dma_stop[c]),
         .drive_tag   (dma_drive[c])
      );
   end

   logic [CH_W-1:0] rd_ch;
   logic [2:0]      rd_sub;
   assign rd_ch  = rd_addr[AW-1:3];
   assign rd_sub = rd_addr[2:0];

   always_comb begin
      rd_data = '0;
      for (int c = 0; c < NCH; c++) begin
         if (rd_ch == CH_W'(c)) begin
            case (rd_sub)
               SUB_CMD: rd_data = {24'h0, cmd_v[c]};
               SUB_STS: rd_data = {24'h0, sts_v[c]};
               SUB_PTR: rd_data = 32'(ptr_v[c]);
               default: rd_data = '0;
            endcase
         end
      end
   end

   assert_pulse_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_start & dma_stop) == '0)
      else $error("start and stop on one channel together");
endmodule

// File: tb/test_busmaster_regs.sv
module test_busmaster_regs;
   localparam int NCH = 2;
   localparam int AW  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bm_en = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [1:0] wr_size = '0;
   logic [31:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic [NCH-1:0] drive_sel = '0;
   logic [2*NCH-1:0] drive_present = '0;
   logic [NCH-1:0] irq_set = '0;
   logic [NCH-1:0] err_set = '0;
   logic [NCH-1:0] dma_start, dma_stop, dma_drive;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   busmaster_regs i_busmaster_regs (
      .clk(clk), .rst_n(rst_n), .bm_en(bm_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .drive_sel(drive_sel),
      .drive_present(drive_present), .irq_set(irq_set), .err_set(err_set),
      .dma_start(dma_start), .dma_stop(dma_stop), .dma_drive(dma_drive)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   // drive at a falling edge; returns at the next falling edge, where the
   // registers and the pulses of that write are visible
   task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] d);
      wr_addr = a; wr_size = sz; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 start", {30'h0, dma_start}, 32'h0);
      chk("R1 stop",  {30'h0, dma_stop},  32'h0);
      rd_chk("R1 cmd0", 4'h0, 32'h00);
      rd_chk("R1 sts0", 4'h2, 32'h60);
      rd_chk("R1 ptr0", 4'h4, 32'h0);
      rd_chk("R1 cmd1", 4'h8, 32'h00);
      rd_chk("R1 sts1", 4'hA, 32'h60);
      rd_chk("R1 ptr1", 4'hC, 32'h0);
   endtask

   task automatic t_cmd_bits();
      wr(4'h0, 2'd0, 32'h08);
      rd_chk("R2 dir bit", 4'h0, 32'h08);
      wr(4'h0, 2'd0, 32'hF6);
      rd_chk("R2 reserved bits", 4'h0, 32'h00);
      rd_chk("R2 unmapped offset", 4'h6, 32'h0);
   endtask

   task automatic t_start_stop();
      drive_present = 4'b0011; drive_sel = 2'b00;
      wr(4'h0, 2'd0, 32'h09);
      chk("R4 start pulse", {30'h0, dma_start}, 32'h1);
      chk("R4 drive tag", {31'h0, dma_drive[0]}, 32'h0);
      rd_chk("R4 active", 4'h2, 32'h61);
      @(negedge clk);
      chk("R4 single pulse", {30'h0, dma_start}, 32'h0);
      wr(4'h0, 2'd0, 32'h01);
      rd_chk("R3 dir locked", 4'h0, 32'h09);
      wr(4'h0, 2'd0, 32'h00);
      chk("R5 stop pulse", {30'h0, dma_stop}, 32'h1);
      rd_chk("R5 active cleared", 4'h2, 32'h60);
      rd_chk("R3 dir kept on stop", 4'h0, 32'h08);
      @(negedge clk);
      chk("R5 single pulse", {30'h0, dma_stop}, 32'h0);
      wr(4'h0, 2'd0, 32'h00);
      rd_chk("R3 dir free when idle", 4'h0, 32'h00);
      drive_sel = 2'b01;
      wr(4'h0, 2'd0, 32'h01);
      chk("R4 drive1 tag", {31'h0, dma_drive[0]}, 32'h1);
      wr(4'h0, 2'd0, 32'h00);
      chk("R5 stop tag", {30'h0, dma_stop, 31'h0, dma_drive[0]} , {30'h0, 2'b01, 31'h0, 1'b1});
      drive_sel = 2'b00;
   endtask

   task automatic t_w1c();
      irq_set = 2'b01;
      @(negedge clk);
      irq_set = 2'b00; err_set = 2'b01;
      @(negedge clk);
      err_set = 2'b00;
      rd_chk("R6 engine sets", 4'h2, 32'h66);
      wr(4'h2, 2'd0, 32'h60);
      rd_chk("R6 write 0 keeps", 4'h2, 32'h66);
      wr(4'h2, 2'd0, 32'h64);
      rd_chk("R6 clear irq", 4'h2, 32'h62);
      wr(4'h2, 2'd0, 32'h62);
      rd_chk("R6 clear err", 4'h2, 32'h60);
      wr(4'h2, 2'd0, 32'h66);
      rd_chk("R6 no sw set", 4'h2, 32'h60);
   endtask

   task automatic t_active_caps();
      wr(4'h0, 2'd0, 32'h01);
      wr(4'h2, 2'd0, 32'h60);
      rd_chk("R7 active kept", 4'h2, 32'h61);
      wr(4'h2, 2'd0, 32'h00);
      rd_chk("R7 caps writable", 4'h2, 32'h01);
      wr(4'h2, 2'd0, 32'hFF);
      rd_chk("R7 caps back", 4'h2, 32'h61);
      wr(4'h0, 2'd0, 32'h00);
      wr(4'h2, 2'd0, 32'h60);
      rd_chk("R7 idle status", 4'h2, 32'h60);
   endtask

   task automatic t_ptr_size();
      wr(4'h4, 2'd2, 32'h1234_5677);
      rd_chk("R8 aligned", 4'h4, 32'h1234_5674);
      wr(4'h4, 2'd0, 32'hFF);
      rd_chk("R9 byte to ptr", 4'h4, 32'h1234_5674);
      wr(4'h0, 2'd1, 32'h09);
      chk("R9 no start on halfword", {30'h0, dma_start}, 32'h0);
      rd_chk("R9 cmd unchanged", 4'h0, 32'h00);
      wr(4'h2, 2'd2, 32'h0);
      rd_chk("R9 dword to sts", 4'h2, 32'h60);
   endtask

   task automatic t_bm_disabled();
      bm_en = 1'b0;
      wr(4'h0, 2'd0, 32'h09);
      chk("R10 no start", {30'h0, dma_start}, 32'h0);
      rd_chk("R10 cmd", 4'h0, 32'h00);
      wr(4'h4, 2'd2, 32'hABCD_0000);
      rd_chk("R10 ptr", 4'h4, 32'h1234_5674);
      bm_en = 1'b1;
   endtask

   task automatic t_race();
      irq_set = 2'b01;
      @(negedge clk);
      irq_set = 2'b01; err_set = 2'b01;
      wr(4'h2, 2'd0, 32'h66);
      irq_set = 2'b00; err_set = 2'b00;
      rd_chk("R11 set wins", 4'h2, 32'h66);
      wr(4'h2, 2'd0, 32'h66);
      rd_chk("R11 later clear", 4'h2, 32'h60);
   endtask

   task automatic t_no_drive();
      drive_present = 4'b0010; drive_sel = 2'b00;
      wr(4'h0, 2'd0, 32'h01);
      chk("R12 no pulse", {30'h0, dma_start}, 32'h0);
      rd_chk("R12 start stays 0", 4'h0, 32'h00);
      rd_chk("R12 error set", 4'h2, 32'h62);
      wr(4'h2, 2'd0, 32'h62);
   endtask

   task automatic t_channels();
      drive_present = 4'b1000; drive_sel = 2'b10;
      wr(4'h8, 2'd0, 32'h09);
      chk("R13 ch1 start", {30'h0, dma_start, 30'h0, dma_drive}, {30'h0, 2'b10, 30'h0, 2'b10});
      rd_chk("R13 ch1 active", 4'hA, 32'h61);
      rd_chk("R13 ch0 untouched", 4'h2, 32'h60);
      wr(4'hC, 2'd2, 32'hFFFF_FFFF);
      rd_chk("R13 ch1 ptr", 4'hC, 32'hFFFF_FFFC);
      rd_chk("R13 ch0 ptr", 4'h4, 32'h1234_5674);
      irq_set = 2'b10;
      @(negedge clk);
      irq_set = 2'b00;
      rd_chk("R13 ch1 irq", 4'hA, 32'h65);
      rd_chk("R13 ch0 no irq", 4'h2, 32'h60);
      wr(4'h8, 2'd0, 32'h00);
      chk("R13 ch1 stop", {30'h0, dma_stop}, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      bm_en = 1'b1;
      t_cmd_bits();
      t_start_stop();
      t_w1c();
      t_active_caps();
      t_ptr_size();
      t_bm_disabled();
      t_race();
      t_no_drive();
      t_channels();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule